// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of an integrating dual-slope analog-to-digital converter. It divides the master clock into a count enable and steps the analog front end through four phases that repeat without pause. The first phase drives the integrator output back to zero. The second shorts the inputs so that offsets can be stored. The third integrates the unknown input for a fixed number of counts. The fourth runs a reference of opposite polarity until the integrator crosses zero again. A single comparator bit, high while the integrator output is above zero, is the only analog feedback.

The number of counts spent in the fourth phase is the reading. The block converts it to three and a half BCD digits and publishes it, together with the input polarity and an overrange flag, on a one-clock done strobe. The zeroing and auto-zero phases vary in length. Their windows depend on whether the last reading was overrange, and the auto-zero phase takes up the slack so that the count from one reference phase to the next stays constant.

Top module: `dual_slope_seq`

## Requirements
- R1: The phases repeat in the order zeroing, auto-zero, integrate, deintegrate. `phase_oh` is one-hot with bit 0 for zeroing, bit 1 for auto-zero, bit 2 for integrate and bit 3 for deintegrate.
- R2: Phase changes happen only on the count enable, which fires once every `CLK_DIV` clocks (4 by default). Every phase therefore lasts a whole multiple of `CLK_DIV` clocks.
- R3: The integrate phase lasts exactly `INT_TICKS` counts.
- R4: Deintegrate ends on the first count whose comparator sample differs from the integrate-end sample. The reading N is the number of counts that came before that one, so the phase lasts N+1 counts.
- R5: If no crossing is seen within `DEINT_MAX` counts, deintegrate ends after `DEINT_MAX` counts. `over_range` is then set and `result_bcd` shows 13'h1FFF.
- R6: `sign_neg` is 1 when the comparator was low on the last integrate count. `ref_neg` is high for the whole deintegrate phase exactly when that sign is positive, and low in every other phase.
- R7: Zeroing ends on the first count at or after its minimum where the comparator sample differs from the sample of the previous count, and no later than its maximum. The window is [`OZ_MIN_N`, `OZ_MAX_N`] after a normal reading and [`OZ_MIN_O`, `OZ_MAX_O`] after an overrange one.
- R8: Auto-zero lasts CYCLE_TICKS − INT_TICKS − (previous deintegrate counts) − (zeroing counts), clamped to [`AZ_MIN_N`, `AZ_MAX_N`] after a normal reading and [`AZ_MIN_O`, `AZ_MAX_O`] after an overrange one.
- R9: `result_bcd` holds the thousands digit (0 or 1) in bit 12, hundreds in [11:8], tens in [7:4] and units in [3:0].
- R10: `result_bcd`, `sign_neg` and `over_range` update on the clock where `conv_done` goes high. `conv_done` is high for one clock, on the same edge on which deintegrate gives way to zeroing.
- R11: `rst_n` low clears all outputs at once, with the zeroing phase shown and the normal windows selected. Its release takes effect through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_hi | input | 1 | Comparator: integrator output above zero |
| phase_oh | output | 4 | One-hot analog switch controls per phase |
| ref_neg | output | 1 | Select negative reference during deintegrate |
| sign_neg | output | 1 | Polarity of the last reading (1 = negative) |
| over_range | output | 1 | Last reading exceeded full scale |
| result_bcd | output | 13 | Last reading, 3½-digit BCD |
| conv_done | output | 1 | One-clock strobe when a reading is published |

## Verification
A behavioural integrator in the bench is driven with every reading from zero to two past full scale, in both polarities. The input is chosen so that the crossing falls half a count between samples, so an off-by-one in the crossing rule, the count capture or the reference polarity shows up as a wrong reading. Readings at full scale minus one, full scale and beyond separate the last valid count from the overrange path and its code. Conversions that follow an overrange one check that the zeroing and auto-zero windows switch and that auto-zero absorbs the remaining counts. A reset asserted during deintegrate, after an overrange negative reading, checks that the outputs clear at once.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [1:0] {
    PH_OZ    = 2'd0,
    PH_AZ    = 2'd1,
    PH_INT   = 2'd2,
    PH_DEINT = 2'd3
  } phase_e;

  localparam int          BCD_W    = 13;
  localparam logic [12:0] OVR_CODE = 13'h1FFF;
endpackage

// File: rtl/dss_tick_gen.sv
module dss_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;

  always_comb begin
    div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick = (div_q == LAST);

  generate
    if (DIV > 1) begin : g_chk
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/dss_bin2bcd.sv
module dss_bin2bcd #(
  parameter int BW = 12
) (
  input  logic [BW-1:0] bin,
  output logic [12:0]   bcd
);
  logic [15:0] acc;

  always_comb begin
    acc = '0;
    for (int i = BW - 1; i >= 0; i--) begin
      for (int d = 0; d < 4; d++) begin
        if (acc[4*d +: 4] >= 4'd5) acc[4*d +: 4] = acc[4*d +: 4] + 4'd3;
      end
      acc = {acc[14:0], bin[i]};
    end
    bcd = acc[12:0];
  end
endmodule

// File: rtl/dss_seq_ctrl.sv
module dss_seq_ctrl
  import dss_pkg::*;
#(
  parameter int INT_TICKS   = 1000,
  parameter int DEINT_MAX   = 2000,
  parameter int CYCLE_TICKS = 4000,
  parameter int OZ_MIN_N    = 11,
  parameter int OZ_MAX_N    = 140,
  parameter int OZ_MIN_O    = 31,
  parameter int OZ_MAX_O    = 640,
  parameter int AZ_MIN_N    = 910,
  parameter int AZ_MAX_N    = 2900,
  parameter int AZ_MIN_O    = 300,
  parameter int AZ_MAX_O    = 910,
  localparam int CW         = $clog2(CYCLE_TICKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          cmp_hi,
  output phase_e        phase,
  output logic          ref_neg,
  output logic          end_evt,
  output logic          end_ovr,
  output logic          end_sign,
  output logic [CW-1:0] end_count
);
  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] dlen_q, dlen_d;
  logic [CW-1:0] azlen_q, azlen_d;
  logic          prev_q, prev_d;
  logic          sign_q, sign_d;
  logic          ovr_q, ovr_d;
  logic [CW-1:0] oz_lo, oz_hi;
  int            az_lo, az_hi, budget, az_pick;
  logic          crossed;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    dlen_d  = dlen_q;
    azlen_d = azlen_q;
    prev_d  = prev_q;
    sign_d  = sign_q;
    ovr_d   = ovr_q;
    end_evt = 1'b0;
    end_ovr = 1'b0;
    oz_lo   = ovr_q ? CW'(OZ_MIN_O - 1) : CW'(OZ_MIN_N - 1);
    oz_hi   = ovr_q ? CW'(OZ_MAX_O - 1) : CW'(OZ_MAX_N - 1);
    az_lo   = ovr_q ? AZ_MIN_O : AZ_MIN_N;
    az_hi   = ovr_q ? AZ_MAX_O : AZ_MAX_N;
    budget  = CYCLE_TICKS - INT_TICKS - int'(dlen_q) - int'(cnt_q) - 1;
    az_pick = (budget < az_lo) ? az_lo : ((budget > az_hi) ? az_hi : budget);
    crossed = (cmp_hi == sign_q);
    if (tick) begin
      prev_d = cmp_hi;
      unique case (phase_q)
        PH_OZ: begin
          if ((cnt_q >= oz_lo && cmp_hi != prev_q) || cnt_q == oz_hi) begin
            phase_d = PH_AZ;
            cnt_d   = '0;
            azlen_d = CW'(az_pick);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_AZ: begin
          if (cnt_q + 1'b1 == azlen_q) begin
            phase_d = PH_INT;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_INT: begin
          if (cnt_q == CW'(INT_TICKS - 1)) begin
            phase_d = PH_DEINT;
            cnt_d   = '0;
            sign_d  = ~cmp_hi;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DEINT: begin
          if (crossed) begin
            end_evt = 1'b1;
            ovr_d   = 1'b0;
            dlen_d  = cnt_q + 1'b1;
            phase_d = PH_OZ;
            cnt_d   = '0;
          end else if (cnt_q == CW'(DEINT_MAX - 1)) begin
            end_evt = 1'b1;
            end_ovr = 1'b1;
            ovr_d   = 1'b1;
            dlen_d  = CW'(DEINT_MAX);
            phase_d = PH_OZ;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: phase_d = PH_OZ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OZ;
      cnt_q   <= '0;
      dlen_q  <= '0;
      azlen_q <= '0;
      prev_q  <= 1'b0;
      sign_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      dlen_q  <= dlen_d;
      azlen_q <= azlen_d;
      prev_q  <= prev_d;
      sign_q  <= sign_d;
      ovr_q   <= ovr_d;
    end
  end

  assign phase     = phase_q;
  assign ref_neg   = (phase_q == PH_DEINT) && !sign_q;
  assign end_sign  = sign_q;
  assign end_count = cnt_q;

  assert_phase_order_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> (phase_q == phase_e'($past(phase_q) + 2'd1)));
  assert_phase_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != $past(phase_q)) |-> $past(tick));
  assert_int_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_INT) |-> (cnt_q < CW'(INT_TICKS)));
  assert_deint_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DEINT) |-> (cnt_q < CW'(DEINT_MAX)));
  assert_refpol_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_DEINT && $past(phase_q) == PH_DEINT) |-> $stable(ref_neg));
  assert_oz_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_OZ) |-> (cnt_q <= oz_hi));
  assert_az_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_AZ) |-> (int'(azlen_q) >= az_lo && int'(azlen_q) <= az_hi));
endmodule

// File: rtl/dual_slope_seq.sv
module dual_slope_seq
  import dss_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int INT_TICKS   = 1000,
  parameter int DEINT_MAX   = 2000,
  parameter int CYCLE_TICKS = 4000,
  parameter int OZ_MIN_N    = 11,
  parameter int OZ_MAX_N    = 140,
  parameter int OZ_MIN_O    = 31,
  parameter int OZ_MAX_O    = 640,
  parameter int AZ_MIN_N    = 910,
  parameter int AZ_MAX_N    = 2900,
  parameter int AZ_MIN_O    = 300,
  parameter int AZ_MAX_O    = 910
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmp_hi,
  output logic [3:0]  phase_oh,
  output logic        ref_neg,
  output logic        sign_neg,
  output logic        over_range,
  output logic [12:0] result_bcd,
  output logic        conv_done
);
  localparam int CW = $clog2(CYCLE_TICKS + 1);

  logic [1:0]    rsync_q;
  logic          rst_i_n;
  logic          tick;
  phase_e        phase;
  logic          end_evt, end_ovr, end_sign;
  logic [CW-1:0] end_count;
  logic [12:0]   bcd_w;
  logic [12:0]   res_q, res_d;
  logic          sgn_q, sgn_d, ovr_q, ovr_d, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  dss_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_i_n), .tick(tick)
  );

  dss_seq_ctrl #(
    .INT_TICKS(INT_TICKS), .DEINT_MAX(DEINT_MAX), .CYCLE_TICKS(CYCLE_TICKS),
    .OZ_MIN_N(OZ_MIN_N), .OZ_MAX_N(OZ_MAX_N), .OZ_MIN_O(OZ_MIN_O), .OZ_MAX_O(OZ_MAX_O),
    .AZ_MIN_N(AZ_MIN_N), .AZ_MAX_N(AZ_MAX_N), .AZ_MIN_O(AZ_MIN_O), .AZ_MAX_O(AZ_MAX_O)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .cmp_hi(cmp_hi),
    .phase(phase), .ref_neg(ref_neg), .end_evt(end_evt), .end_ovr(end_ovr),
    .end_sign(end_sign), .end_count(end_count)
  );

  dss_bin2bcd #(.BW(CW)) u_bcd (
    .bin(end_count), .bcd(bcd_w)
  );

  generate
    for (genvar p = 0; p < 4; p++) begin : g_oh
      assign phase_oh[p] = (phase == phase_e'(p));
    end
  endgenerate

  always_comb begin
    res_d = res_q;
    sgn_d = sgn_q;
    ovr_d = ovr_q;
    if (end_evt) begin
      res_d = end_ovr ? OVR_CODE : bcd_w;
      sgn_d = end_sign;
      ovr_d = end_ovr;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      res_q  <= '0;
      sgn_q  <= 1'b0;
      ovr_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      res_q  <= res_d;
      sgn_q  <= sgn_d;
      ovr_q  <= ovr_d;
      done_q <= end_evt;
    end
  end

  assign result_bcd = res_q;
  assign sign_neg   = sgn_q;
  assign over_range = ovr_q;
  assign conv_done  = done_q;

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    conv_done |=> !conv_done);
  assert_done_at_phase_wrap_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    conv_done |-> (phase_oh == 4'b0001));
  assert_ovr_code_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    over_range |-> (result_bcd == OVR_CODE));
  assert_bcd_digits_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !over_range |-> (result_bcd[11:8] <= 4'd9 && result_bcd[7:4] <= 4'd9 && result_bcd[3:0] <= 4'd9));
endmodule

// File: tb/tb_dual_slope_seq.sv
`timescale 1ns/1ps
module tb_dual_slope_seq;
  localparam int DIV = 4;
  localparam int INT = 20;
  localparam int DM  = 40;
  localparam int CYC = 80;
  localparam int OZN_LO = 2,  OZN_HI = 6,  OZO_LO = 3, OZO_HI = 12;
  localparam int AZN_LO = 10, AZN_HI = 55, AZO_LO = 5, AZO_HI = 20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmp_hi;
  logic [3:0]  phase_oh;
  logic        ref_neg, sign_neg, over_range, conv_done;
  logic [12:0] result_bcd;

  int n_chk = 0;
  int n_err = 0;
  int xint  = 0;
  int a_stp = 0;
  bit cur_neg = 1'b0;
  bit warm = 1'b0;
  bit done_prev = 1'b0;
  bit finished = 1'b0;
  logic [3:0] prev_ph = 4'b0001;
  int run = 0;
  int oz_t = 0;
  int dlen_prev = 0;
  int last_deint = 0;

  always #4 clk = ~clk;

  dual_slope_seq #(
    .CLK_DIV(DIV), .INT_TICKS(INT), .DEINT_MAX(DM), .CYCLE_TICKS(CYC),
    .OZ_MIN_N(OZN_LO), .OZ_MAX_N(OZN_HI), .OZ_MIN_O(OZO_LO), .OZ_MAX_O(OZO_HI),
    .AZ_MIN_N(AZN_LO), .AZ_MAX_N(AZN_HI), .AZ_MIN_O(AZO_LO), .AZ_MAX_O(AZO_HI)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmp_hi(cmp_hi), .phase_oh(phase_oh),
    .ref_neg(ref_neg), .sign_neg(sign_neg), .over_range(over_range),
    .result_bcd(result_bcd), .conv_done(conv_done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [12:0] exp_bcd(input int n);
    return {(n >= 1000) ? 1'b1 : 1'b0, 4'((n / 100) % 10), 4'((n / 10) % 10), 4'(n % 10)};
  endfunction

  task automatic wrap_up();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // behavioural integrator: updated away from the sampling edge
  always @(negedge clk) begin
    if (!rst_n)           xint = 0;
    else if (phase_oh[1]) xint = 0;
    else if (phase_oh[2]) xint = xint + a_stp;
    else if (phase_oh[3]) xint = xint + (ref_neg ? -2 * INT : 2 * INT);
    else                  xint = (xint > 0) ? xint - 20 : xint + 30;
    cmp_hi = (xint > 0);
  end

  // phase monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_ph = 4'b0001; run = 0; warm = 1'b0; dlen_prev = 0; done_prev = 1'b0;
    end else begin
      if (conv_done) begin
        chk(prev_ph == 4'b1000 && phase_oh == 4'b0001, "R10 done at deint end", int'(phase_oh), 1);
        chk(!done_prev, "R10 done width", 2, 1);
      end
      done_prev = conv_done;
      if (phase_oh != prev_ph) begin
        chk(phase_oh == {prev_ph[2:0], prev_ph[3]}, "R1 order", int'(phase_oh),
            int'({prev_ph[2:0], prev_ph[3]}));
        if (warm) chk(run % DIV == 0, "R2 length multiple", run, (run / DIV) * DIV);
        chk(ref_neg == (phase_oh[3] && !cur_neg), "R6 ref select", int'(ref_neg),
            int'(phase_oh[3] && !cur_neg));
        if (prev_ph[0] && warm) begin
          oz_t = run / DIV;
          chk(oz_t >= (over_range ? OZO_LO : OZN_LO) && oz_t <= (over_range ? OZO_HI : OZN_HI),
              "R7 zeroing window", oz_t, over_range ? OZO_LO : OZN_LO);
        end
        if (prev_ph[1] && warm) begin
          int lo, hi, b, e;
          lo = over_range ? AZO_LO : AZN_LO;
          hi = over_range ? AZO_HI : AZN_HI;
          b  = CYC - INT - dlen_prev - oz_t;
          e  = (b < lo) ? lo : ((b > hi) ? hi : b);
          chk(run == e * DIV, "R8 auto-zero length", run / DIV, e);
        end
        if (prev_ph[2]) chk(run == INT * DIV, "R3 integrate length", run, INT * DIV);
        if (prev_ph[3]) begin
          last_deint = run;
          dlen_prev  = run / DIV;
          warm       = 1'b1;
        end
        run = 1;
      end else begin
        run++;
      end
      prev_ph = phase_oh;
    end
  end

  task automatic run_conv(input int n, input bit neg);
    bit ovr;
    int len;
    while (!phase_oh[1]) @(negedge clk);
    cur_neg = neg;
    a_stp = neg ? -(2 * n + 1) : (2 * n + 1);
    while (!conv_done) @(negedge clk);
    ovr = (n >= DM);
    chk(result_bcd == (ovr ? 13'h1FFF : exp_bcd(n)), ovr ? "R5 overrange code" : "R9 bcd reading",
        int'(result_bcd), ovr ? 8191 : int'(exp_bcd(n)));
    chk(sign_neg == neg, "R6 sign", int'(sign_neg), int'(neg));
    chk(over_range == ovr, "R5 flag", int'(over_range), int'(ovr));
    @(negedge clk);
    len = (ovr ? DM : n + 1) * DIV;
    chk(last_deint == len, ovr ? "R5 deint length" : "R4 deint length", last_deint, len);
  endtask

  initial begin
    rst_n  = 1'b0;
    cmp_hi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phase_oh == 4'b0001, "R11 reset phase", int'(phase_oh), 1);
    chk(result_bcd == 13'd0 && !over_range && !sign_neg && !conv_done && !ref_neg,
        "R11 reset outputs", int'(result_bcd), 0);
    for (int n = 0; n <= DM + 1; n++) run_conv(n, 1'b0);
    for (int n = 0; n <= DM + 1; n++) run_conv(n, 1'b1);
    run_conv(5, 1'b0);
    run_conv(DM + 1, 1'b1);
    while (!phase_oh[3]) @(negedge clk);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(phase_oh == 4'b0001, "R11 async reset phase", int'(phase_oh), 1);
    chk(result_bcd == 13'd0 && !over_range && !sign_neg && !conv_done && !ref_neg,
        "R11 async reset outputs", int'(result_bcd), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    run_conv(12, 1'b0);
    wrap_up();
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    wrap_up();
  end
endmodule